// File: doc/BRIEF.md
# Time Code Host Register Port

This block sits between a byte-wide processor bus and the internal engines of a time code peripheral. A processor reaches it through six direct registers selected by a 3-bit address. Two of them form an indirect window onto sixteen byte-wide registers. Indirect registers 0 to 7 show the frame most recently captured by the time code receiver. Indirect registers 8 to 15 hold the frame the time code transmitter sends next. One direct register holds the window index, and another carries the data at that index. When the top bit of the written index byte is set, the index steps forward after every data access, so a whole frame can be moved with one index write followed by a burst of data accesses.

The block also collects single-cycle event pulses from four internal sources into a status register. One read of that register returns the pending flags and clears all four of them. A serial-port path keeps a receive-pending flag and a transmit-ready flag. Reading the serial data register clears the first, and writing it clears the second. An enable register masks each of the six flags onto one interrupt output.

Top module: `host_regif`

## Requirements
- R1: After reset the status flags, enable mask, index, auto-step bit, transmit bank, serial flags and `irq` are all zero, and `uart_tx_push` is low.
- R2: A write to address 2 sets the index from bits 3:0 and the auto-step bit from bit 7. A read of address 2 returns {auto-step, 3'b000, index}.
- R3: A read of address 3 returns indirect register `index`. Registers 0..7 are byte `index` of `rx_frame` (bits 8*index+7 : 8*index), and registers 8..15 are the stored transmit bytes.
- R4: A write to address 3 with index 8..15 stores the byte, which appears on `tx_frame` bits 8*(index-8)+7 : 8*(index-8). A write with index 0..7 changes no state.
- R5: With auto-step set, the index increments after every read or write of address 3. With auto-step clear, it holds.
- R6: During auto-step the index wraps from 15 to 0.
- R7: A pulse on `ev_ltc_rx`, `ev_ltc_tx`, `ev_line` or `ev_timer` sets status bit 0, 1, 2 or 3 respectively, and the bit is read at address 0 from the next cycle on.
- R8: A read of address 0 returns the four flags in bits 3:0 (other bits zero) and clears all four on the following cycle.
- R9: An event pulse in the same cycle as a status read is not returned by that read, and its flag stays set afterwards.
- R10: `irq` is high when any of {uart tx-ready, uart rx-pending, timer, line, ltc tx, ltc rx} is set together with its bit in the enable register (address 1, bits 5:0 in that order from bit 5 to bit 0). Address 1 reads back {2'b00, mask}.
- R11: A `uart_rx_valid` pulse stores `uart_rx_byte` and sets bit 0 of address 4. A read of address 5 returns the stored byte and clears that bit.
- R12: A `uart_tx_ready` pulse sets bit 1 of address 4. A write to address 5 clears that bit, and in the next cycle `uart_tx_push` pulses for one cycle with the written byte on `uart_tx_byte`.
- R13: When a serial flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Direct register select |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; ignored while bus_wr is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| ev_ltc_rx | input | 1 | Receiver frame-captured pulse |
| ev_ltc_tx | input | 1 | Transmitter frame-loaded pulse |
| ev_line | input | 1 | Video line count pulse |
| ev_timer | input | 1 | Timer pulse |
| rx_frame | input | 64 | Captured receive frame, byte i for indirect register i |
| tx_frame | output | 64 | Transmit bank, byte j for indirect register 8+j |
| uart_rx_valid | input | 1 | Serial byte received pulse |
| uart_rx_byte | input | 8 | Received serial byte |
| uart_tx_ready | input | 1 | Serial transmitter can take a byte, pulse |
| uart_tx_push | output | 1 | One-cycle push of a byte to the serial transmitter |
| uart_tx_byte | output | 8 | Byte being pushed |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case is an event that lands in the very cycle the host reads the status register or a serial data register. The read must return the old state while the new event survives. The stimulus drives event pulses in the same cycle as the read strobes, both in directed steps and during a long stretch of random bus traffic with random events. A behavioural model that clears before it sets then catches any lost event. Index wrap is reached by starting an auto-step burst at index 15.

// File: rtl/host_regif_pkg.sv
package host_regif_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_ENABLE = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_WINDOW = 3'd3,
    SEL_USTAT  = 3'd4,
    SEL_UDATA  = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/event_flags.sv
module event_flags #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev,
  input  logic             rd_clr,
  output logic [N_SRC-1:0] flags
);
  logic [N_SRC-1:0] flags_q, flags_d;

  // clear first, then merge new events so a coincident event survives
  always_comb begin
    flags_d = (rd_clr ? '0 : flags_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

  p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ev == '0) |=> (flags == '0));

  p_event_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((flags & $past(ev)) == $past(ev)));
endmodule

// File: rtl/window_bank.sv
module window_bank #(
  parameter int IDX_W   = 4,
  parameter int DATA_W  = 8,
  parameter int RX_REGS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          idx_we,
  input  logic                          idx_step_in,
  input  logic [IDX_W-1:0]              idx_in,
  input  logic                          acc_rd,
  input  logic                          acc_wr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [RX_REGS*DATA_W-1:0]     rx_frame,
  output logic [IDX_W-1:0]              idx,
  output logic                          idx_step,
  output logic [DATA_W-1:0]             rdata,
  output logic [((1<<IDX_W)-RX_REGS)*DATA_W-1:0] tx_frame
);
  localparam int NREG    = 1 << IDX_W;
  localparam int TX_REGS = NREG - RX_REGS;

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step_q, step_d;
  logic [NREG-1:0][DATA_W-1:0] view;

  always_comb begin
    idx_d  = idx_q;
    step_d = step_q;
    if (idx_we) begin
      idx_d  = idx_in;
      step_d = idx_step_in;
    end else if ((acc_rd || acc_wr) && step_q) begin
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      step_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      step_q <= step_d;
    end
  end

  for (genvar i = 0; i < RX_REGS; i++) begin : g_rx
    assign view[i] = rx_frame[i*DATA_W +: DATA_W];
  end

  for (genvar j = 0; j < TX_REGS; j++) begin : g_tx
    logic              we;
    logic [DATA_W-1:0] byte_q;
    assign we = acc_wr && (idx_q == IDX_W'(RX_REGS + j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  byte_q <= '0;
      else if (we) byte_q <= wdata;
    end
    assign view[RX_REGS + j]            = byte_q;
    assign tx_frame[j*DATA_W +: DATA_W] = byte_q;
  end

  assign rdata    = view[idx_q];
  assign idx      = idx_q;
  assign idx_step = step_q;

  p_autoinc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_rd || acc_wr) && step_q && !idx_we) |=> (idx == IDX_W'($past(idx) + 1'b1)));

  p_hold_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_we && !step_q) |=> $stable(idx));
endmodule

// File: rtl/serial_flags.sv
module serial_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_take,
  input  logic              tx_ready,
  input  logic              tx_load,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              rx_pend,
  output logic              tx_pend,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_push,
  output logic [DATA_W-1:0] tx_byte
);
  logic              rxp_q, rxp_d, txp_q, txp_d, push_q;
  logic [DATA_W-1:0] rxb_q, txb_q;

  // set has priority over clear on both flags
  always_comb begin
    rxp_d = (rxp_q && !rx_take) || rx_valid;
    txp_d = (txp_q && !tx_load) || tx_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxp_q  <= 1'b0;
      txp_q  <= 1'b0;
      push_q <= 1'b0;
    end else begin
      rxp_q  <= rxp_d;
      txp_q  <= txp_d;
      push_q <= tx_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rxb_q <= '0;
    else if (rx_valid) rxb_q <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       txb_q <= '0;
    else if (tx_load) txb_q <= tx_wdata;
  end

  assign rx_pend = rxp_q;
  assign tx_pend = txp_q;
  assign rx_data = rxb_q;
  assign tx_push = push_q;
  assign tx_byte = txb_q;

  p_push_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_push && tx_byte == $past(tx_wdata)));

  p_rx_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_pend);

  p_tx_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> tx_pend);
endmodule

// File: rtl/host_regif.sv
module host_regif
  import host_regif_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int RX_REGS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2:0]                bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [BYTE_W-1:0]         bus_wdata,
  output logic [BYTE_W-1:0]         bus_rdata,
  input  logic                      ev_ltc_rx,
  input  logic                      ev_ltc_tx,
  input  logic                      ev_line,
  input  logic                      ev_timer,
  input  logic [RX_REGS*BYTE_W-1:0] rx_frame,
  output logic [((1<<IDX_W)-RX_REGS)*BYTE_W-1:0] tx_frame,
  input  logic                      uart_rx_valid,
  input  logic [BYTE_W-1:0]         uart_rx_byte,
  input  logic                      uart_tx_ready,
  output logic                      uart_tx_push,
  output logic [BYTE_W-1:0]         uart_tx_byte,
  output logic                      irq
);
  localparam int N_SRC = 4;
  localparam int EN_W  = N_SRC + 2;

  reg_sel_e          sel;
  logic              wr, rd;
  logic [N_SRC-1:0]  flags;
  logic [EN_W-1:0]   en_q, en_d;
  logic [IDX_W-1:0]  idx;
  logic              idx_step;
  logic [BYTE_W-1:0] win_rdata, rx_data;
  logic              rx_pend, tx_pend;

  assign sel = reg_sel_e'(bus_addr);
  assign wr  = bus_wr;
  assign rd  = bus_rd && !bus_wr;

  event_flags #(.N_SRC(N_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     ({ev_timer, ev_line, ev_ltc_tx, ev_ltc_rx}),
    .rd_clr (rd && sel == SEL_STATUS),
    .flags  (flags)
  );

  window_bank #(.IDX_W(IDX_W), .DATA_W(BYTE_W), .RX_REGS(RX_REGS)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .idx_we      (wr && sel == SEL_INDEX),
    .idx_step_in (bus_wdata[BYTE_W-1]),
    .idx_in      (bus_wdata[IDX_W-1:0]),
    .acc_rd      (rd && sel == SEL_WINDOW),
    .acc_wr      (wr && sel == SEL_WINDOW),
    .wdata       (bus_wdata),
    .rx_frame    (rx_frame),
    .idx         (idx),
    .idx_step    (idx_step),
    .rdata       (win_rdata),
    .tx_frame    (tx_frame)
  );

  serial_flags #(.DATA_W(BYTE_W)) u_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (uart_rx_valid),
    .rx_byte  (uart_rx_byte),
    .rx_take  (rd && sel == SEL_UDATA),
    .tx_ready (uart_tx_ready),
    .tx_load  (wr && sel == SEL_UDATA),
    .tx_wdata (bus_wdata),
    .rx_pend  (rx_pend),
    .tx_pend  (tx_pend),
    .rx_data  (rx_data),
    .tx_push  (uart_tx_push),
    .tx_byte  (uart_tx_byte)
  );

  always_comb begin
    en_d = en_q;
    if (wr && sel == SEL_ENABLE) en_d = bus_wdata[EN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_STATUS: bus_rdata = BYTE_W'(flags);
      SEL_ENABLE: bus_rdata = BYTE_W'(en_q);
      SEL_INDEX:  bus_rdata = {idx_step, (BYTE_W-1-IDX_W)'(0), idx};
      SEL_WINDOW: bus_rdata = win_rdata;
      SEL_USTAT:  bus_rdata = BYTE_W'({tx_pend, rx_pend});
      SEL_UDATA:  bus_rdata = rx_data;
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = |({tx_pend, rx_pend, flags} & en_q);

  p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  p_irq_follows_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_timer && en_q[3] && !(wr && sel == SEL_ENABLE)) |=> irq);
endmodule

// File: tb/host_regif_test.sv
`timescale 1ns/1ps
module host_regif_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_wdata, bus_rdata;
  logic        ev_ltc_rx, ev_ltc_tx, ev_line, ev_timer;
  logic [63:0] rx_frame, tx_frame;
  logic        uart_rx_valid, uart_tx_ready, uart_tx_push;
  logic [7:0]  uart_rx_byte, uart_tx_byte;
  logic        irq;

  host_regif uut (.*);

  always #2.5 clk = ~clk;

  int vec = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] m_tx [8];
  int         m_idx;
  bit         m_ai;
  logic [3:0] m_flags;
  logic [5:0] m_en;
  bit         m_urx, m_utx, m_push;
  logic [7:0] m_rxb, m_pushb;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vec++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    case (bus_addr)
      3'd0: return {4'b0, m_flags};
      3'd1: return {2'b0, m_en};
      3'd2: return {m_ai, 3'b0, 4'(m_idx)};
      3'd3: return (m_idx < 8) ? rx_frame[m_idx*8 +: 8] : m_tx[m_idx-8];
      3'd4: return {6'b0, m_utx, m_urx};
      3'd5: return m_rxb;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R8 status";
      3'd1: return "R10 enable";
      3'd2: return "R2 index";
      3'd3: return "R3 window";
      3'd4: return "R11 uart status";
      3'd5: return "R11 uart data";
      default: return "R3 reserved";
    endcase
  endfunction

  function automatic logic [63:0] exp_tx();
    logic [63:0] v;
    for (int j = 0; j < 8; j++) v[j*8 +: 8] = m_tx[j];
    return v;
  endfunction

  task automatic model_reset();
    for (int j = 0; j < 8; j++) m_tx[j] = 8'h00;
    m_idx = 0; m_ai = 0; m_flags = 0; m_en = 0;
    m_urx = 0; m_utx = 0; m_push = 0; m_rxb = 0; m_pushb = 0;
  endtask

  // model update at the clock edge (inputs are stable there)
  always @(posedge clk) begin
    if (rst_n) begin
      bit w, r;
      w = bus_wr;
      r = bus_rd && !bus_wr;
      m_push = 0;
      if (w) begin
        case (bus_addr)
          3'd1: m_en = bus_wdata[5:0];
          3'd2: begin m_ai = bus_wdata[7]; m_idx = bus_wdata[3:0]; end
          3'd3: begin
            if (m_idx >= 8) m_tx[m_idx-8] = bus_wdata;
            if (m_ai) m_idx = (m_idx + 1) % 16;
          end
          3'd5: begin m_push = 1; m_pushb = bus_wdata; m_utx = 0; end
          default: ;
        endcase
      end else if (r) begin
        case (bus_addr)
          3'd0: m_flags = 4'h0;
          3'd3: if (m_ai) m_idx = (m_idx + 1) % 16;
          3'd5: m_urx = 0;
          default: ;
        endcase
      end
      m_flags = m_flags | {ev_timer, ev_line, ev_ltc_tx, ev_ltc_rx};
      if (uart_rx_valid) begin m_urx = 1; m_rxb = uart_rx_byte; end
      if (uart_tx_ready) m_utx = 1;
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      chk(tag_of(bus_addr), {56'b0, bus_rdata}, {56'b0, exp_rdata()});
      chk("R10 irq", {63'b0, irq}, {63'b0, |({m_utx, m_urx, m_flags} & m_en)});
      chk("R4 tx_frame", tx_frame, exp_tx());
      chk("R12 push", {63'b0, uart_tx_push}, {63'b0, m_push});
      if (m_push) chk("R12 push byte", {56'b0, uart_tx_byte}, {56'b0, m_pushb});
    end
  end

  // pending side inputs for the next op
  logic [3:0] nx_ev = 0;
  bit         nx_urx = 0, nx_utx = 0;
  logic [7:0] nx_urxb = 0;

  task automatic op(input logic [2:0] a, input bit w, input bit r, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
    {ev_timer, ev_line, ev_ltc_tx, ev_ltc_rx} = nx_ev;
    uart_rx_valid = nx_urx; uart_rx_byte = nx_urxb; uart_tx_ready = nx_utx;
    nx_ev = 0; nx_urx = 0; nx_utx = 0;
    #1;
  endtask

  task automatic idle(); op(3'd7, 0, 0, 8'h00); endtask

  initial begin
    #(5.0 * 150000);
    bad++; vec++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    ev_ltc_rx = 0; ev_ltc_tx = 0; ev_line = 0; ev_timer = 0;
    uart_rx_valid = 0; uart_rx_byte = 0; uart_tx_ready = 0;
    for (int i = 0; i < 8; i++) rx_frame[i*8 +: 8] = 8'h10 + 8'(i * 17);
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state at the ports
    chk("R1 status", {56'b0, bus_rdata}, 64'h0);
    chk("R1 irq", {63'b0, irq}, 64'h0);
    chk("R1 tx_frame", tx_frame, 64'h0);
    chk("R1 push", {63'b0, uart_tx_push}, 64'h0);
    @(negedge clk); rst_n = 1;
    idle();

    // R2: index write and readback
    op(3'd2, 1, 0, 8'h05); op(3'd2, 0, 1, 8'h00);
    chk("R2 index plain", {56'b0, bus_rdata}, 64'h05);
    op(3'd2, 1, 0, 8'h8A); op(3'd2, 0, 1, 8'h00);
    chk("R2 index step", {56'b0, bus_rdata}, 64'h8A);

    // R3 and R5: burst read of receive bytes 0..7
    op(3'd2, 1, 0, 8'h80);
    for (int i = 0; i < 8; i++) begin
      op(3'd3, 0, 1, 8'h00);
      chk("R3 burst read", {56'b0, bus_rdata}, {56'b0, rx_frame[i*8 +: 8]});
    end

    // R4: burst write of transmit bank
    op(3'd2, 1, 0, 8'h88);
    for (int j = 0; j < 8; j++) op(3'd3, 1, 0, 8'hA0 + 8'(j));
    idle();
    chk("R4 tx bank", tx_frame, 64'hA7A6A5A4A3A2A1A0);
    // R4: write to receive range ignored
    op(3'd2, 1, 0, 8'h03); op(3'd3, 1, 0, 8'hEE); op(3'd3, 0, 1, 8'h00);
    chk("R4 rx write ignored", {56'b0, bus_rdata}, {56'b0, rx_frame[31:24]});
    chk("R4 tx untouched", tx_frame, 64'hA7A6A5A4A3A2A1A0);

    // R5: no step without the top bit
    op(3'd2, 1, 0, 8'h09); op(3'd3, 0, 1, 8'h00); op(3'd3, 0, 1, 8'h00);
    chk("R5 hold", {56'b0, bus_rdata}, 64'hA1);
    op(3'd2, 0, 1, 8'h00);
    chk("R5 index held", {56'b0, bus_rdata}, 64'h09);

    // R6: wrap from 15 to 0
    op(3'd2, 1, 0, 8'h8F); op(3'd3, 0, 1, 8'h00);
    chk("R6 last", {56'b0, bus_rdata}, 64'hA7);
    op(3'd3, 0, 1, 8'h00);
    chk("R6 wrap", {56'b0, bus_rdata}, {56'b0, rx_frame[7:0]});

    // R7 and R8: each source, then clearing read
    for (int s = 0; s < 4; s++) begin
      nx_ev = 4'(1 << s); idle();
      op(3'd0, 0, 1, 8'h00);
      chk("R7 flag set", {56'b0, bus_rdata}, 64'(1 << s));
      op(3'd0, 0, 1, 8'h00);
      chk("R8 cleared", {56'b0, bus_rdata}, 64'h0);
    end

    // R9: event coincident with the status read
    nx_ev = 4'b0101; idle();
    nx_ev = 4'b1010; op(3'd0, 0, 1, 8'h00);
    chk("R9 old value", {56'b0, bus_rdata}, 64'h05);
    op(3'd0, 0, 1, 8'h00);
    chk("R9 kept", {56'b0, bus_rdata}, 64'h0A);

    // R10: masking
    op(3'd1, 1, 0, 8'h08); nx_ev = 4'b0001; idle();
    chk("R10 masked", {63'b0, irq}, 64'h0);
    nx_ev = 4'b1000; idle(); idle();
    chk("R10 enabled", {63'b0, irq}, 64'h1);
    op(3'd0, 0, 1, 8'h00); idle();
    chk("R10 cleared", {63'b0, irq}, 64'h0);

    // R11 and R13: serial receive
    op(3'd1, 1, 0, 8'h30);
    nx_urx = 1; nx_urxb = 8'h5C; idle(); idle();
    chk("R11 rx irq", {63'b0, irq}, 64'h1);
    op(3'd5, 0, 1, 8'h00);
    chk("R11 rx data", {56'b0, bus_rdata}, 64'h5C);
    op(3'd4, 0, 1, 8'h00);
    chk("R11 rx cleared", {56'b0, bus_rdata}, 64'h0);
    nx_urx = 1; nx_urxb = 8'h11; idle();
    nx_urx = 1; nx_urxb = 8'h22; op(3'd5, 0, 1, 8'h00);
    chk("R13 read old", {56'b0, bus_rdata}, 64'h11);
    op(3'd4, 0, 1, 8'h00);
    chk("R13 rx set wins", {56'b0, bus_rdata}, 64'h01);
    op(3'd5, 0, 1, 8'h00);

    // R12 and R13: serial transmit
    nx_utx = 1; idle(); op(3'd4, 0, 1, 8'h00);
    chk("R12 tx ready", {56'b0, bus_rdata}, 64'h02);
    op(3'd5, 1, 0, 8'h6B); idle();
    chk("R12 push", {55'b0, uart_tx_push, uart_tx_byte}, 64'h16B);
    op(3'd4, 0, 1, 8'h00);
    chk("R12 tx cleared", {56'b0, bus_rdata}, 64'h0);
    nx_utx = 1; op(3'd5, 1, 0, 8'h77); op(3'd4, 0, 1, 8'h00);
    chk("R13 tx set wins", {56'b0, bus_rdata}, 64'h02);

    // mixed random traffic checked by the model
    for (int k = 0; k < 3000; k++) begin
      logic [2:0] a;
      bit w;
      a = 3'($urandom_range(0, 7));
      w = ($urandom_range(0, 3) == 0);
      nx_ev = 4'($urandom);
      nx_ev = nx_ev & 4'($urandom);
      nx_urx = ($urandom_range(0, 5) == 0);
      nx_urxb = 8'($urandom);
      nx_utx = ($urandom_range(0, 5) == 0);
      if (a == 3'd6) rx_frame = {$urandom, $urandom};
      op(a, w, !w && $urandom_range(0, 1) == 1, 8'($urandom));
    end
    idle(); idle();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule